// File: doc/BRIEF.md
# Converter Fault and Power-Good Supervisor

This block watches the comparator results of a synchronous buck converter. It samples them once per switching cycle and decides when the converter must stop. Each fault source has its own run-length filter. Each source is also armed at its own point relative to soft-start:

- Under-voltage and over-voltage are ignored until soft-start has finished.
- Current limit is watched from the first cycle.
- A high-side short is acted on at once, with no filter.
- Over-temperature trips at once and blocks any restart until a cool flag is seen.

All fault sources feed one shared fault latch. The latch raises the shutdown flag and forces power-good low.

Restart goes through the enable pin. While the latch is set, the block turns on a current sink on the enable pin and removes the pull-up. It holds that state until the pin falls under its lower threshold and the die has cooled. It then restores the pull-up. A new soft-start begins once the pin climbs over its upper threshold.

If the enable pin is driven high from outside, the discharge never completes and the converter stays latched off. If the enable pin is left floating, the converter restarts at once.

Top module: `fault_pg_supervisor`

## Requirements
- R1: After reset, shutdown is 1, pgood is 0, en_pullup_on is 1 and en_sink_on is 0. The supervisor leaves shutdown (shutdown goes to 0) on the clock after en_above_hi is 1.
- R2: While ss_done is 1, fb_uv on UV_CYCLES consecutive ticks sets the fault latch. While ss_done is 0, fb_uv never sets it.
- R3: While ss_done is 1, fb_ov on OV_CYCLES consecutive ticks sets the fault latch. While ss_done is 0, fb_ov never sets it.
- R4: ilim_trip on OC_CYCLES consecutive ticks sets the fault latch, whatever the value of ss_done.
- R5: sw_hi_ls_on sets the fault latch on the next clock edge, without waiting for a tick.
- R6: ot_hot sets the fault latch on the next edge. After that, en_sink_on stays 1 until ot_cool has been seen, even when the enable pin is already low.
- R7: pgood is 1 only while running with ss_done at 1. It goes to 0 once pg_win_bad has been 1 on PG_CYCLES consecutive ticks, and returns to 1 after the first tick on which pg_win_bad is 0.
- R8: While the fault latch is set, shutdown is 1, pgood is 0, en_sink_on is 1 and en_pullup_on is 0. The latch releases (en_sink_on 0, en_pullup_on 1) on the clock after en_above_lo is 0, once the die has cooled. A new run starts on the clock after en_above_hi is 1.
- R9: While en_above_lo stays 1, the fault latch never releases (latched off).
- R10: A tick on which a condition is 0 restarts its count from zero, so broken runs never set the fault latch. Cycles without a tick do not count.
- R11: While running, en_above_lo at 0 sends the block to standby: shutdown is 1, en_sink_on is 0 and en_pullup_on is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| fb_uv | input | 1 | Feedback below the under-voltage level |
| fb_ov | input | 1 | Feedback above the over-voltage level |
| pg_win_bad | input | 1 | Feedback outside the power-good window |
| ilim_trip | input | 1 | Current limit tripped in this cycle |
| sw_hi_ls_on | input | 1 | Switch node high while the low-side switch is fully on |
| ot_hot | input | 1 | Die over-temperature |
| ot_cool | input | 1 | Die back below the recovery temperature |
| ss_done | input | 1 | Soft-start complete |
| en_above_hi | input | 1 | Enable pin above the upper (start) threshold |
| en_above_lo | input | 1 | Enable pin above the lower (discharge) threshold |
| shutdown | output | 1 | Converter must stop switching |
| pgood | output | 1 | Power-good |
| en_sink_on | output | 1 | Enable-pin discharge sink on |
| en_pullup_on | output | 1 | Enable-pin pull-up on |

## Verification
The bench builds the block with its default filter lengths: 16 ticks for under-voltage and current limit, and 2 ticks for over-voltage and the power-good window. These lengths are short enough that each threshold can be hit exactly. The bench then compares a run of one tick less against a run of the full length, and a run broken by a single clean tick. A fixed table of power-good window patterns exercises the two-tick filter on the way down and its release on the first clean tick.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } sup_state_e;

  // Index of each run-length filter inside the filter bank
  localparam int unsigned FI_UV = 0;
  localparam int unsigned FI_OV = 1;
  localparam int unsigned FI_OC = 2;
  localparam int unsigned FI_PG = 3;
  localparam int unsigned N_FILT = 4;

endpackage

// File: rtl/cycle_filter.sv
module cycle_filter #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  // next run length: zero on a clean sample, saturate at LEN
  function automatic logic [CW-1:0] run_step(input logic [CW-1:0] c, input logic s);
    if (!s)
      return '0;
    if (c == CW'(LEN))
      return c;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= run_step(cnt_q, cond);
  end

  assign hit = (cnt_q == CW'(LEN));
endmodule

// File: rtl/restart_fsm.sv
module restart_fsm
  import fpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_evt,
  input  logic       ot_hot,
  input  logic       ot_cool,
  input  logic       en_above_hi,
  input  logic       en_above_lo,
  output sup_state_e state,
  output logic       hot_hold
);
  sup_state_e state_d;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hot_hold <= 1'b0;
    else if (ot_hot)
      hot_hold <= 1'b1;
    else if (ot_cool)
      hot_hold <= 1'b0;
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_OFF:   if (en_above_hi && !hot_hold) state_d = ST_RUN;
      ST_RUN:   if (fault_evt) state_d = ST_FAULT;
                else if (!en_above_lo) state_d = ST_OFF;
      ST_FAULT: if (!en_above_lo && !hot_hold) state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= ST_OFF;
    else
      state <= state_d;
  end
endmodule

// File: rtl/fault_pg_supervisor.sv
module fault_pg_supervisor
  import fpg_pkg::*;
#(
  parameter int unsigned UV_CYCLES = 16,
  parameter int unsigned OV_CYCLES = 2,
  parameter int unsigned OC_CYCLES = 16,
  parameter int unsigned PG_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic fb_uv,
  input  logic fb_ov,
  input  logic pg_win_bad,
  input  logic ilim_trip,
  input  logic sw_hi_ls_on,
  input  logic ot_hot,
  input  logic ot_cool,
  input  logic ss_done,
  input  logic en_above_hi,
  input  logic en_above_lo,
  output logic shutdown,
  output logic pgood,
  output logic en_sink_on,
  output logic en_pullup_on
);
  function automatic int unsigned filt_len(input int unsigned idx);
    case (idx)
      FI_UV:   return UV_CYCLES;
      FI_OV:   return OV_CYCLES;
      FI_OC:   return OC_CYCLES;
      default: return PG_CYCLES;
    endcase
  endfunction

  sup_state_e        state;
  logic              hot_hold;
  logic              running;
  logic [N_FILT-1:0] filt_cond;
  logic [N_FILT-1:0] filt_hit;
  logic              uv_hit, ov_hit, oc_hit, pg_hit;
  logic              fault_evt;

  assign running = (state == ST_RUN);

  // arming: feedback faults wait for soft-start, current limit does not
  always_comb begin
    filt_cond        = '0;
    filt_cond[FI_UV] = fb_uv & ss_done;
    filt_cond[FI_OV] = fb_ov & ss_done;
    filt_cond[FI_OC] = ilim_trip;
    filt_cond[FI_PG] = pg_win_bad;
  end

  for (genvar g = 0; g < N_FILT; g++) begin : g_filt
    cycle_filter #(.LEN(filt_len(g))) i_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!running),
      .tick (cyc_tick),
      .cond (filt_cond[g]),
      .hit  (filt_hit[g])
    );
  end

  assign uv_hit = filt_hit[FI_UV];
  assign ov_hit = filt_hit[FI_OV];
  assign oc_hit = filt_hit[FI_OC];
  assign pg_hit = filt_hit[FI_PG];

  assign fault_evt = uv_hit | ov_hit | oc_hit | sw_hi_ls_on | ot_hot;

  restart_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_evt  (fault_evt),
    .ot_hot     (ot_hot),
    .ot_cool    (ot_cool),
    .en_above_hi(en_above_hi),
    .en_above_lo(en_above_lo),
    .state      (state),
    .hot_hold   (hot_hold)
  );

  assign shutdown     = !running;
  assign pgood        = running & ss_done & !pg_hit;
  assign en_sink_on   = (state == ST_FAULT);
  assign en_pullup_on = (state != ST_FAULT);
endmodule

// File: rtl/fault_pg_supervisor_chk.sv
module fault_pg_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_hi_ls_on,
  input logic ot_hot,
  input logic ss_done,
  input logic en_above_lo,
  input logic shutdown,
  input logic pgood,
  input logic en_sink_on,
  input logic fault_evt,
  input logic ov_hit,
  input logic hot_hold
);
  // R5
  short_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hi_ls_on && !shutdown) |=> en_sink_on);

  // R3
  ov_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_hit && !shutdown) |=> (shutdown && en_sink_on));

  // R6
  hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sink_on && hot_hold) |=> en_sink_on);

  // R7
  pg_softstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> ss_done);

  // R8
  pg_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_sink_on |-> (!pgood && shutdown));

  // R9
  latched_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sink_on && en_above_lo) |=> en_sink_on);

  // R11
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !en_above_lo && !fault_evt) |=> (shutdown && !en_sink_on));

  // R6
  ot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_hot && !shutdown) |=> en_sink_on);
endmodule

bind fault_pg_supervisor fault_pg_supervisor_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_hi_ls_on(sw_hi_ls_on),
  .ot_hot     (ot_hot),
  .ss_done    (ss_done),
  .en_above_lo(en_above_lo),
  .shutdown   (shutdown),
  .pgood      (pgood),
  .en_sink_on (en_sink_on),
  .fault_evt  (fault_evt),
  .ov_hit     (ov_hit),
  .hot_hold   (hot_hold)
);

// File: tb/test_fault_pg_supervisor.sv
module test_fault_pg_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_tick = 0, fb_uv = 0, fb_ov = 0, pg_win_bad = 0, ilim_trip = 0;
  logic sw_hi_ls_on = 0, ot_hot = 0, ot_cool = 0, ss_done = 0;
  logic en_above_hi = 0, en_above_lo = 0;
  logic shutdown, pgood, en_sink_on, en_pullup_on;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fault_pg_supervisor i_fault_pg_supervisor (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .fb_uv(fb_uv), .fb_ov(fb_ov),
    .pg_win_bad(pg_win_bad), .ilim_trip(ilim_trip), .sw_hi_ls_on(sw_hi_ls_on),
    .ot_hot(ot_hot), .ot_cool(ot_cool), .ss_done(ss_done),
    .en_above_hi(en_above_hi), .en_above_lo(en_above_lo),
    .shutdown(shutdown), .pgood(pgood), .en_sink_on(en_sink_on),
    .en_pullup_on(en_pullup_on)
  );

  // {pg_win_bad, expected pgood after the tick}
  localparam logic [1:0] PG_VEC [9] = '{
    2'b01, 2'b11, 2'b10, 2'b10, 2'b01, 2'b11, 2'b01, 2'b11, 2'b10
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_tick = 1'b1;
      @(negedge clk);
      cyc_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic restart();
    en_above_hi = 1'b0;
    en_above_lo = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en_above_lo = 1'b1;
    en_above_hi = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 shutdown", shutdown, 1'b1);
    chk("R1 pgood", pgood, 1'b0);
    chk("R1 pullup", en_pullup_on, 1'b1);
    chk("R1 sink", en_sink_on, 1'b0);
    en_above_lo = 1'b1;
    en_above_hi = 1'b1;
    @(negedge clk);
    chk("R1 start", shutdown, 1'b0);
    chk("R7 pgood before ss_done", pgood, 1'b0);

    // R7 window filter table
    ss_done = 1'b1;
    foreach (PG_VEC[k]) begin
      pg_win_bad = PG_VEC[k][1];
      do_ticks(1);
      chk("R7 pgood vector", pgood, PG_VEC[k][0]);
    end
    pg_win_bad = 1'b0;
    do_ticks(1);

    // R2 not armed before soft-start
    ss_done = 1'b0;
    fb_uv = 1'b1;
    do_ticks(20);
    chk("R2 uv ignored in soft-start", shutdown, 1'b0);
    ss_done = 1'b1;
    do_ticks(15);
    chk("R2 uv 15 ticks", shutdown, 1'b0);
    do_ticks(1);
    chk("R2 uv 16 ticks", shutdown, 1'b1);
    chk("R8 sink", en_sink_on, 1'b1);
    chk("R8 pullup", en_pullup_on, 1'b0);
    fb_uv = 1'b0;
    chk("R8 pgood in fault", pgood, 1'b0);
    // R9 enable held high
    repeat (10) @(negedge clk);
    chk("R9 latched off", en_sink_on, 1'b1);
    chk("R9 shutdown", shutdown, 1'b1);
    en_above_hi = 1'b0;
    en_above_lo = 1'b0;
    @(negedge clk);
    chk("R8 release sink", en_sink_on, 1'b0);
    chk("R8 release pullup", en_pullup_on, 1'b1);
    en_above_lo = 1'b1;
    en_above_hi = 1'b1;
    @(negedge clk);
    chk("R8 new run", shutdown, 1'b0);

    // R10 broken runs and no-tick cycles
    fb_uv = 1'b1;
    do_ticks(15);
    fb_uv = 1'b0;
    do_ticks(1);
    fb_uv = 1'b1;
    do_ticks(15);
    repeat (40) @(negedge clk);
    chk("R10 broken run", shutdown, 1'b0);
    fb_uv = 1'b0;
    do_ticks(1);

    // R3 over-voltage
    ss_done = 1'b0;
    fb_ov = 1'b1;
    do_ticks(5);
    chk("R3 ov ignored in soft-start", shutdown, 1'b0);
    ss_done = 1'b1;
    do_ticks(1);
    chk("R3 ov 1 tick", shutdown, 1'b0);
    do_ticks(1);
    chk("R3 ov 2 ticks", shutdown, 1'b1);
    fb_ov = 1'b0;
    restart();
    chk("R8 restart after ov", shutdown, 1'b0);

    // R4 current limit active during soft-start
    ss_done = 1'b0;
    ilim_trip = 1'b1;
    do_ticks(15);
    chk("R4 oc 15 ticks", shutdown, 1'b0);
    do_ticks(1);
    chk("R4 oc 16 ticks", shutdown, 1'b1);
    ilim_trip = 1'b0;
    restart();

    // R5 high-side short
    sw_hi_ls_on = 1'b1;
    @(negedge clk);
    sw_hi_ls_on = 1'b0;
    chk("R5 short", en_sink_on, 1'b1);
    restart();
    chk("R5 restart", shutdown, 1'b0);

    // R6 over-temperature
    ot_hot = 1'b1;
    @(negedge clk);
    ot_hot = 1'b0;
    chk("R6 ot trip", shutdown, 1'b1);
    en_above_hi = 1'b0;
    en_above_lo = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 held while hot", en_sink_on, 1'b1);
    ot_cool = 1'b1;
    @(negedge clk);
    ot_cool = 1'b0;
    @(negedge clk);
    chk("R6 release after cool", en_sink_on, 1'b0);
    en_above_lo = 1'b1;
    en_above_hi = 1'b1;
    @(negedge clk);
    chk("R6 new run", shutdown, 1'b0);

    // R11 standby via enable
    en_above_hi = 1'b0;
    en_above_lo = 1'b0;
    @(negedge clk);
    chk("R11 standby", shutdown, 1'b1);
    chk("R11 no sink", en_sink_on, 1'b0);
    chk("R11 pullup", en_pullup_on, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule